// File: doc/BRIEF.md
# Queued-Transmit SPI Master

This block is the shifting core of an SPI master. It moves 8-bit words most significant bit first. On each word it drives SCK and MOSI and samples MISO. A host hands bytes in over a valid/ready stream. Behind that stream sits a one-entry holding register, so the next byte can wait while the current one is on the wire. When the current word ends, the waiting byte goes straight into the shift register. Several such bytes form one unbroken burst of SCK cycles. Each byte that is clocked in is presented on a receive stream with a valid flag.

The bit clock comes from a divider of the system clock. The divider runs continuously while the block is both enabled and in master mode. A transfer therefore begins only on the next bit boundary of that divider, and the delay before it starts varies by up to one bit time. The host selects one of four bit-time ratios. SCK idle polarity and clock phase are set by two plain control inputs. These controls, together with the ratio, should change only while the block is switched off.

Back-pressure rules. On the transmit side, a byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is the transmit-empty flag. On the receive side, `rx_valid` is the receive-full flag, and a cycle with `rx_ready` high consumes the byte. The serial side cannot be stalled. A byte that completes while the previous one is still unread replaces it, and `rx_valid` stays high.

Top module: `spi_q_master`

## Requirements
- R1: After reset, `rx_valid` is 0 and `mosi` is 0. `sck` equals `cpol`. `tx_ready` is 1 as soon as `enable` and `master_mode` are both high.
- R2: A byte is accepted only on an edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 while the holding register holds a byte. Asserting `tx_valid` while `tx_ready` is 0 has no effect on the transmitted data.
- R3: The four ratio codes are fixed: `div_sel` 0, 1, 2 and 3 give bit times of 2, 8, 32 and 128 system clocks. SCK changes level only on half-bit boundaries, and each byte produces exactly 8 SCK cycles (16 level changes).
- R4: A transfer begins on a bit boundary no more than one bit time after the edge that accepted the byte. With `cpha`=1 the first SCK change is at that start. With `cpha`=0 the first SCK change comes half a bit later.
- R5: With `cpha`=0, each bit time starts with SCK at its idle level and switches to the active level halfway through. MISO is sampled at the idle-to-active change, and MOSI moves to the next bit at the active-to-idle change.
- R6: With `cpha`=1, each bit time starts with a change of SCK from idle to active, and MOSI moves to the next bit there. SCK returns to idle at mid-bit, where MISO is sampled.
- R7: MOSI carries the byte most significant bit first. It is 0 whenever no transfer is in progress.
- R8: At the end of the 8th bit, the sampled bits (the first sample becomes bit 7) are placed on `rx_data` and `rx_valid` is set. A cycle with `rx_ready`=1 clears `rx_valid`, unless a word completes in that same cycle. An unread byte is overwritten by the next one.
- R9: A byte waiting in the holding register starts in the same cycle that the previous byte ends. No idle half-bit separates the two bytes.
- R10: While `enable` or `master_mode` is 0, the divider is held at zero. Any transfer is dropped, the holding register is emptied, and `tx_ready` is 0. From the following cycle on, `sck` equals `cpol` and `mosi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable |
| master_mode | input | 1 | Master-mode select; needed with `enable` to run |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase: 0 samples on the first edge of a bit, 1 on the second |
| div_sel | input | 2 | Bit-time ratio code (2, 8, 32, 128 clocks) |
| tx_data | input | 8 | Byte offered for transmission |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmit-empty flag; holding register can take a byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Receive-full flag |
| rx_ready | input | 1 | Consumer takes the received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The embedded properties watch, on every clock, the following behaviours:
- acceptance fills the holding register;
- a held byte stays untouched by further offers;
- divider ticks never come back-to-back above the fastest ratio;
- SCK moves only on a tick;
- a waiting byte chains directly into the next word;
- each completed word raises the receive flag;
- the serial pins fall quiet once the block is switched off.

Other behaviours show up only in the bench's scenarios:
- bit order and the exact sampling half-bit of each clock phase;
- the variable start latency and its bound;
- the absence of a gap in a two-byte burst;
- the overwrite of an unread byte.

These are checked there against a cycle-level behavioural model, with MISO fed from a pseudo-random sequence.

// File: rtl/spi_q_pkg.sv
package spi_q_pkg;

  localparam int unsigned SEL_W = 2;

  typedef logic [SEL_W-1:0] div_sel_t;

  // Number of system clocks in half a bit time for a ratio code.
  function automatic int unsigned half_period(input div_sel_t sel, input int unsigned step_log);
    return 32'd1 << (step_log * 32'(sel));
  endfunction

endpackage

// File: rtl/spi_q_divider.sv
module spi_q_divider
  import spi_q_pkg::*;
#(
  parameter int unsigned STEP_LOG = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  div_sel_t div_sel,
  output logic     half_tick,
  output logic     phase
);

  localparam int unsigned CW = STEP_LOG * 3 + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = CW'(half_period(div_sel, STEP_LOG) - 32'd1);

  assign half_tick = run && (cnt >= lim);

  // Free-running count; phase marks the second half of each bit time.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (half_tick) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && div_sel != '0) |=> (!half_tick || !$stable(div_sel))); // R3

endmodule

// File: rtl/spi_q_txhold.sv
module spi_q_txhold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  input  logic          take,
  output logic          hold_full,
  output logic [DW-1:0] hold_data
);

  logic accept;

  assign tx_ready = run && !hold_full;
  assign accept   = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (!run) begin
      hold_full <= 1'b0;
    end else if (take) begin
      hold_full <= 1'b0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_data <= tx_data;
    end
  end

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (hold_full && !tx_ready)); // R2

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !take && run) |=> (hold_full && $stable(hold_data))); // R2

endmodule

// File: rtl/spi_q_shifter.sv
module spi_q_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          half_tick,
  input  logic          phase,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          miso,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  output logic          take,
  output logic          sck,
  output logic          mosi,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready
);

  localparam int unsigned NHALF = 2 * DW;
  localparam int unsigned HW    = $clog2(NHALF);
  localparam logic [HW-1:0] LAST = HW'(NHALF - 1);

  logic          busy;
  logic [HW-1:0] h;
  logic [DW-1:0] shreg;
  logic          samp;
  logic          last_tick;
  logic          lvl;

  assign last_tick = busy && half_tick && (h == LAST);
  // New words begin only on a bit boundary (phase high at the tick).
  assign take      = half_tick && phase && hold_full && (!busy || h == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      h     <= '0;
      shreg <= '0;
      samp  <= 1'b0;
    end else if (!run) begin
      busy <= 1'b0;
      h    <= '0;
    end else if (take) begin
      busy  <= 1'b1;
      h     <= '0;
      shreg <= hold_data;
    end else if (busy && half_tick) begin
      if (h == LAST) begin
        busy <= 1'b0;
        h    <= '0;
      end else begin
        h <= h + 1'b1;
        if (!h[0]) samp  <= miso;
        else       shreg <= {shreg[DW-2:0], samp};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (last_tick) begin
      rx_data  <= {shreg[DW-2:0], samp};
      rx_valid <= 1'b1;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  // Even half-periods: idle for phase 0, active for phase 1.
  assign lvl  = busy && (cpha ? !h[0] : h[0]);
  assign sck  = cpol ^ lvl;
  assign mosi = busy && shreg[DW-1];

  AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half_tick && h == LAST && hold_full) |=> (busy && h == '0 && !hold_full)); // R9

  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half_tick && h == LAST) |=> rx_valid); // R8

endmodule

// File: rtl/spi_q_master.sv
module spi_q_master
  import spi_q_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned STEP_LOG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          master_mode,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [1:0]    div_sel,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic          sck,
  output logic          mosi,
  input  logic          miso
);

  logic          run;
  logic          half_tick;
  logic          phase;
  logic          take;
  logic          hold_full;
  logic [DW-1:0] hold_data;

  assign run = enable && master_mode;

  spi_q_divider #(.STEP_LOG(STEP_LOG)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .div_sel   (div_sel_t'(div_sel)),
    .half_tick (half_tick),
    .phase     (phase)
  );

  spi_q_txhold #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .take      (take),
    .hold_full (hold_full),
    .hold_data (hold_data)
  );

  spi_q_shifter #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .half_tick (half_tick),
    .phase     (phase),
    .cpol      (cpol),
    .cpha      (cpha),
    .miso      (miso),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .take      (take),
    .sck       (sck),
    .mosi      (mosi),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready)
  );

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (run || (sck == cpol && !mosi))); // R10

  AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_tick) |=> (!run || $stable(sck) || !$stable(cpol) || !$stable(cpha))); // R3

endmodule

// File: tb/spi_q_master_test.sv
`timescale 1ns/100ps
module spi_q_master_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, master_mode = 1'b0, cpol = 1'b0, cpha = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_ready = 1'b1;
  logic       sck, mosi;
  logic       miso = 1'b0;

  int total = 0, bad = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  spi_q_master uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master_mode(master_mode),
    .cpol(cpol), .cpha(cpha), .div_sel(div_sel), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pseudo-random MISO, changed away from the active edge.
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    miso <= lfsr[0];
    lfsr <= {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
  end

  // Behavioural reference model, advanced on every rising edge.
  int       m_cnt = 0, m_pos = 0, m_sh = 0, m_rx = 0;
  bit       m_ph = 0, m_act = 0, m_samp = 0, m_rxv = 0;
  byte unsigned q[$];

  always @(posedge clk or negedge rst_n) begin : model
    int  hp;
    bit  run_now, tick, fin, acc;
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_act = 0; m_pos = 0; m_sh = 0; m_samp = 0;
      m_rx = 0; m_rxv = 0; q.delete();
    end else begin
      hp = 1 << (2 * div_sel);
      run_now = enable && master_mode;
      fin = 0;
      if (!run_now) begin
        m_cnt = 0; m_ph = 0; m_act = 0; m_pos = 0; q.delete();
      end else begin
        tick = (m_cnt >= hp - 1);
        acc  = tx_valid && (q.size() == 0);
        if (tick && m_act && m_pos == 15) begin
          m_rx = ((m_sh << 1) | m_samp) & 255;
          fin = 1;
        end
        if (tick && m_ph && q.size() > 0 && (!m_act || m_pos == 15)) begin
          m_sh = q.pop_front(); m_act = 1; m_pos = 0;
        end else if (tick && m_act) begin
          if (m_pos == 15) begin
            m_act = 0; m_pos = 0;
          end else begin
            if (m_pos % 2 == 0) m_samp = miso;
            else m_sh = ((m_sh << 1) | m_samp) & 255;
            m_pos++;
          end
        end
        if (acc) q.push_back(tx_data);
        if (tick) begin m_cnt = 0; m_ph = !m_ph; end
        else m_cnt++;
      end
      if (fin) m_rxv = 1;
      else if (rx_ready) m_rxv = 0;
    end
  end

  // Per-cycle comparison and SCK edge monitor, 1 ns after the edge.
  int cyc = 0, tog = 0, first_t = -1, last_t = -1;
  logic prev_sck = 1'b0;
  always @(posedge clk) begin
    bit run_now, lv;
    #1;
    cyc++;
    if (sck !== prev_sck) begin
      tog++;
      if (first_t < 0) first_t = cyc;
      last_t = cyc;
    end
    prev_sck = sck;
    if (rst_n) begin
      run_now = enable && master_mode;
      lv = m_act && (cpha ? (m_pos % 2 == 0) : (m_pos % 2 == 1));
      check(tx_ready === (run_now && q.size() == 0), run_now ? "R2 tx_ready" : "R10 tx_ready",
            int'(tx_ready), int'(run_now && q.size() == 0));
      check(sck === (cpol ^ lv), !run_now ? "R10 sck" : (cpha ? "R6 sck" : "R5 sck"),
            int'(sck), int'(cpol ^ lv));
      check(mosi === (m_act && ((m_sh >> 7) & 1)), run_now ? "R7 mosi" : "R10 mosi",
            int'(mosi), int'(m_act && ((m_sh >> 7) & 1)));
      check(rx_valid === m_rxv, "R8 rx_valid", int'(rx_valid), int'(m_rxv));
      check(int'(rx_data) == m_rx, "R8 rx_data", int'(rx_data), m_rx);
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle;
    while (m_act || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic configure(input bit p, input bit a, input int d);
    @(negedge clk); enable = 1'b0;
    repeat (2) @(negedge clk);
    cpol = p; cpha = a; div_sel = 2'(d);
    @(negedge clk); enable = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_config(input bit p, input bit a, input int d, input logic [7:0] seed);
    int hp, k, lim;
    hp = 1 << (2 * d);
    configure(p, a, d);
    // single byte: start latency and SCK cycle count
    rx_ready = 1'b1;
    tog = 0; first_t = -1;
    send(seed);
    k = 0;
    while (sck == cpol && k < 1000) begin @(negedge clk); k++; end
    lim = a ? 2 * hp : 3 * hp;
    check(k >= 1 && k <= lim, "R4 start latency", k, lim);
    wait_idle();
    check(tog == 16, "R3 sck changes per byte", tog, 16);
    // two queued bytes, one refused offer, unread receive data
    rx_ready = 1'b0;
    tog = 0; first_t = -1;
    send(~seed);
    send(seed ^ 8'h3C);
    @(negedge clk);
    check(tx_ready == 1'b0, "R2 holding occupied", int'(tx_ready), 0);
    tx_valid = 1'b1; tx_data = 8'hEE;
    @(negedge clk);
    tx_valid = 1'b0;
    wait_idle();
    check(tog == 32, "R9 sck changes in burst", tog, 32);
    check(last_t - first_t == 31 * hp, "R9 burst span", last_t - first_t, 31 * hp);
    check(rx_valid == 1'b1 && int'(rx_data) == m_rx, "R8 overwrite kept", int'(rx_data), m_rx);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
    check(rx_valid == 1'b0, "R8 cleared by read", int'(rx_valid), 0);
    rx_ready = 1'b1;
  endtask

  initial begin : main
    rst_n = 1'b0;
    enable = 1'b1; master_mode = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
    check(mosi == 1'b0, "R1 mosi", int'(mosi), 0);
    check(sck == cpol, "R1 sck", int'(sck), int'(cpol));
    check(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);

    for (int m = 0; m < 4; m++) run_config(m[0], m[1], 0, 8'hA5 + 8'(m));
    run_config(1'b0, 1'b1, 1, 8'h81);
    run_config(1'b1, 1'b0, 2, 8'h3E);
    run_config(1'b1, 1'b1, 3, 8'hC6);

    // switch-off in the middle of a word
    configure(1'b1, 1'b0, 1);
    send(8'h5A);
    repeat (12) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(sck == 1'b1, "R10 sck idle", int'(sck), 1);
    check(mosi == 1'b0, "R10 mosi low", int'(mosi), 0);
    check(tx_ready == 1'b0, "R10 tx_ready", int'(tx_ready), 0);
    enable = 1'b1;
    send(8'h96);
    wait_idle();
    check(int'(rx_data) == m_rx, "R8 after restart", int'(rx_data), m_rx);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      bad++;
      total++;
      $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule